// File: doc/BRIEF.md
# CMI Line Encoder with Violation Injection

This block turns a serial NRZ transmit stream into Coded Mark Inversion half-bit symbols for a line driver. It runs from one clock at twice the bit rate, so each clock cycle is one half-bit. An internal phase register splits the clock into bit periods. The block shows the capture point on `bit_strobe`, which takes the place of the falling edge of a transmit bit clock. The line cannot stall, so there is no valid/ready handshake and no back-pressure. `bit_strobe` acts as a free-running ready: the source must present a bit in every strobe cycle, and the encoder never waits.

A zero is sent as low then high. A one is sent as a full-bit level that alternates between high and low on successive ones. When `viol_req` is high at capture, the block breaks the code on purpose, for zero bits and for one bits. A request that stays high is honoured for a limited number of consecutive bits (five by default) and is ignored after that until it has been low at a capture. While `rst_n` is low, the line pair is released (`line_oe` low), modelling the high-impedance state of the driver.

Top module: `cmi_line_encoder`

## Requirements
- R1: `bit_strobe` is high in every second clock cycle after reset release, starting in the first cycle. `tx_bit` and `viol_req` are sampled only at the rising edge that ends a strobe cycle. Values on them in other cycles have no effect on the line.
- R2: A captured zero without a honoured violation is sent as `line_p` low in the first half-bit and high in the second.
- R3: A captured one without a honoured violation is sent at one level for both half-bits. That level is the inverse of the one-polarity state, which then takes that level. The state is low after reset, so the first one after reset is sent high.
- R4: A captured zero with a honoured violation is sent as `line_p` high then low.
- R5: A captured one with a honoured violation repeats the level of the previous one for both half-bits and leaves the one-polarity state unchanged.
- R6: While `viol_req` is high at consecutive captures, only the first VIOL_LIMIT (5) of them are honoured. Later ones are encoded as normal bits until a capture sees `viol_req` low, which resets the count.
- R7: The first half-bit of a captured bit appears on the line in the clock cycle right after the capture edge, and the second half-bit in the cycle after that.
- R8: While `rst_n` is low, `line_oe`, `line_p`, `line_n` and `bit_strobe` are all low.
- R9: Whenever `line_oe` is high, `line_n` is the logical complement of `line_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (twice the bit rate) |
| rst_n | input | 1 | Active-low asynchronous reset; releases the line while low |
| tx_bit | input | 1 | NRZ transmit bit, sampled at the end of a strobe cycle |
| viol_req | input | 1 | Request for a code rule violation on the captured bit |
| bit_strobe | output | 1 | High in the cycle whose ending edge captures the inputs |
| line_p | output | 1 | Positive line level |
| line_n | output | 1 | Negative line level, complement of `line_p` when enabled |
| line_oe | output | 1 | Line drive enable; low models high impedance |

## Verification
A directed opening sequence of ones, zeros and single violations checks that the first one after reset is high and that ones alternate. It also checks that a violated one repeats the previous level without moving the alternation. A held request that spans more than five captures, followed by a short release and a new request, separates a correct saturating count from one that wraps, never saturates or fails to clear. Long random streams with bursts of requests compare every half-bit with a bench model. Garbage driven on the inputs between captures shows that sampling happens only at the strobe edge. A reset in mid-stream checks that the line is released and that the polarity and count restart.

// File: rtl/cmi_enc_pkg.sv
package cmi_enc_pkg;
  typedef struct packed {
    logic first_half;
    logic second_half;
  } cmi_sym_t;

  localparam cmi_sym_t SYM_ZERO      = '{first_half: 1'b0, second_half: 1'b1};
  localparam cmi_sym_t SYM_ZERO_VIOL = '{first_half: 1'b1, second_half: 1'b0};
endpackage

// File: rtl/cmi_phase_gen.sv
module cmi_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic take,
  output logic shift,
  output logic drive_en
);
  logic ph_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      ph_q <= ~ph_q;
      en_q <= 1'b1;
    end
  end

  // capture edge ends a cycle with ph high; shift edge ends a cycle with ph low
  assign take     = ph_q;
  assign shift    = en_q & ~ph_q;
  assign drive_en = en_q;

  // R1
  strobe_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
endmodule

// File: rtl/cmi_viol_limiter.sv
module cmi_viol_limiter #(
  parameter int VIOL_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic req,
  output logic honour
);
  localparam int CW = $clog2(VIOL_LIMIT + 1);
  localparam logic [CW-1:0] CAP = CW'(VIOL_LIMIT);

  logic [CW-1:0] run_q;

  assign honour = req && (run_q < CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (take) begin
      if (!req)            run_q <= '0;
      else if (run_q != CAP) run_q <= run_q + 1'b1;
    end
  end

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req && run_q == CAP) |=> (run_q == CAP));

  // R6
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req) |=> (run_q == '0));
endmodule

// File: rtl/cmi_symbol_map.sv
module cmi_symbol_map
  import cmi_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic shift,
  input  logic data_bit,
  input  logic viol,
  output logic line_lvl
);
  cmi_sym_t sym;
  logic     pol_q;
  logic     half2_q;
  logic     line_q;
  logic     mark_lvl;

  always_comb begin
    mark_lvl = viol ? pol_q : ~pol_q;
    if (data_bit) sym = '{first_half: mark_lvl, second_half: mark_lvl};
    else          sym = viol ? SYM_ZERO_VIOL : SYM_ZERO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= 1'b0;
      half2_q <= 1'b0;
      line_q  <= 1'b0;
    end else if (take) begin
      line_q  <= sym.first_half;
      half2_q <= sym.second_half;
      if (data_bit && !viol) pol_q <= ~pol_q;
    end else if (shift) begin
      line_q <= half2_q;
    end
  end

  assign line_lvl = line_q;

  // R2
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !data_bit && !viol) |=> (!line_q ##1 line_q));

  // R4
  zero_viol_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !data_bit && viol) |=> (line_q ##1 !line_q));

  // R3
  one_full_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && data_bit) |=> ##1 $stable(line_q));

  // R5
  viol_one_keeps_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && data_bit && viol) |=> $stable(pol_q));
endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder #(
  parameter int VIOL_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_bit,
  input  logic viol_req,
  output logic bit_strobe,
  output logic line_p,
  output logic line_n,
  output logic line_oe
);
  logic take;
  logic shift;
  logic drive_en;
  logic honour;
  logic line_lvl;

  cmi_phase_gen u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .shift    (shift),
    .drive_en (drive_en)
  );

  cmi_viol_limiter #(.VIOL_LIMIT(VIOL_LIMIT)) u_limit (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .req    (viol_req),
    .honour (honour)
  );

  cmi_symbol_map u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .shift    (shift),
    .data_bit (tx_bit),
    .viol     (honour),
    .line_lvl (line_lvl)
  );

  assign bit_strobe = take;
  assign line_oe    = drive_en;
  assign line_p     = drive_en &  line_lvl;
  assign line_n     = drive_en & ~line_lvl;

  // R8
  released_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !$past(bit_strobe));
endmodule

// File: tb/tb_cmi_line_encoder.sv
`timescale 1ns/1ps
module tb_cmi_line_encoder;
  localparam int LIM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_bit = 1'b0;
  logic viol_req = 1'b0;
  logic bit_strobe, line_p, line_n, line_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic pol_m;
  int   run_m;

  always #10 clk = ~clk;

  cmi_line_encoder #(.VIOL_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .viol_req(viol_req),
    .bit_strobe(bit_strobe), .line_p(line_p), .line_n(line_n), .line_oe(line_oe)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model_sym(input logic b, input logic hon, input logic pol);
    if (b) return hon ? {pol, pol} : {~pol, ~pol};
    return hon ? 2'b10 : 2'b01;
  endfunction

  task automatic check_reset_state();
    chk("R8 oe", line_oe, 1'b0);
    chk("R8 p", line_p, 1'b0);
    chk("R8 n", line_n, 1'b0);
    chk("R8 strobe", bit_strobe, 1'b0);
  endtask

  task automatic send(input logic b, input logic v);
    logic hon;
    logic [1:0] e;
    string tag;
    while (!bit_strobe) @(negedge clk);
    tx_bit = b;
    viol_req = v;
    hon = v && (run_m < LIM);
    e = model_sym(b, hon, pol_m);
    if (b && !hon) pol_m = ~pol_m;
    if (!v) run_m = 0;
    else if (run_m < LIM) run_m++;
    if (v && !hon)   tag = b ? "R6 ignored one" : "R6 ignored zero";
    else if (b)      tag = hon ? "R5 viol one" : "R3 one";
    else             tag = hon ? "R4 viol zero" : "R2 zero";
    @(negedge clk);
    chk({tag, " R7 first half"}, line_p, e[1]);
    chk("R9 complement", line_n, ~line_p);
    chk("R1 strobe low", bit_strobe, 1'b0);
    // R1: garbage between captures must not reach the line
    tx_bit = ~b;
    viol_req = 1'($urandom);
    @(negedge clk);
    chk({tag, " R7 second half R1"}, line_p, e[0]);
    chk("R9 complement", line_n, ~line_p);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pol_m = 1'b0;
    run_m = 0;
    @(negedge clk);
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe first cycle", bit_strobe, 1'b1);
    chk("R8 oe after release", line_oe, 1'b1);
  endtask

  initial begin
    int unused_seed;
    logic v;
    unused_seed = int'($urandom(32'd2024));
    pol_m = 1'b0;
    run_m = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe first cycle", bit_strobe, 1'b1);

    // directed: alternation and first-one polarity (R3), violations (R4, R5)
    send(1'b1, 1'b0);
    send(1'b1, 1'b0);
    send(1'b0, 1'b0);
    send(1'b1, 1'b1);
    send(1'b1, 1'b0);
    send(1'b0, 1'b1);
    send(1'b0, 1'b0);
    // R6: held request over eight captures, then release and new burst
    for (int i = 0; i < 8; i++) send(1'(i % 2), 1'b1);
    send(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) send(1'b1, 1'b1);

    // random streams with request bursts
    v = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(3) == 0) v = ~v;
      send(1'($urandom), v);
    end

    // mid-stream reset: polarity and count restart (R8, R3, R6)
    do_reset();
    send(1'b1, 1'b0);
    for (int i = 0; i < 7; i++) send(1'b0, 1'b1);
    for (int i = 0; i < 200; i++) send(1'($urandom), 1'($urandom));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule